// File: doc/BRIEF.md
# Late-Write SRAM Data Path with Coherent Bypass

This block is the write-data and read-return path of a synchronous SRAM that uses a late-write protocol. Each clock cycle it takes at most one command: a read or a write, with an address. A write command and its address are sampled on one rising edge. The data for that write is sampled on the following rising edge. The captured write goes into a holding register and is committed to a small internal register file later, at the first suitable edge. A read presents its address on one edge and returns the data on the next edge through an output register.

The array may hold stale contents while a write sits in the holding register. Reads therefore compare their address with the holding register and take the held data when the two match. Reads and writes may be mixed in any order with no dead cycles. A read may follow a write to the same address directly and still returns the new data.

The command and read-return streams are marked by valid flags only. There is no back-pressure: the block accepts a command on every edge and never stalls a read. The data for a write must be present on the edge after its command, and `wr_data` is ignored on all other edges.

Top module: `latewr_sram`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rd_data` is 0. Every array entry reads back 0 until it is written.
- R2: A read command (`cmd_valid`=1, `cmd_write`=0) sampled on edge k drives `rd_valid` high for exactly the cycle that follows edge k+1, with its data on `rd_data`. `rd_valid` is never high at any other time.
- R3: For a write command (`cmd_valid`=1, `cmd_write`=1) sampled on edge k, the write data is taken from `wr_data` on edge k+1. `wr_data` has no effect on any other edge.
- R4: A read sampled on the edge directly after a write command to the same address returns that write's data. This is the same edge on which the write data is sampled.
- R5: Reads and writes may alternate on consecutive edges with no idle cycles, and every read returns the latest data written to its address.
- R6: When two writes to the same address are still waiting to be committed, the newer data wins. This holds for reads made while the writes are pending and for the array contents once both are committed.
- R7: In any cycle where `rd_valid` is 0, `rd_data` keeps the value of the last read.
- R8: A captured write is committed to the array on the first edge that has no read command. It is also committed on an edge where newer write data arrives. A run of reads of any length returns the held data for a matching address, and returns array data for every other address.
- R9: A read of an address with no pending write returns the value most recently committed to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read (only when `cmd_valid`) |
| cmd_addr | input | AW | Command address |
| wr_data | input | DW | Write data, sampled on the edge after a write command |
| rd_valid | output | 1 | `rd_data` carries the result of a read this cycle |
| rd_data | output | DW | Registered read data, held between reads |

## Verification
The hardest case to reach is a forced commit. Here the holding register is still occupied by one write when the data for a second write arrives on an edge that also carries a read. The old entry must then drain into the array while the new entry takes its place, and a read in the same cycle must still see the right value. The stimulus reaches this case with a write, a write and a read on consecutive edges, to the same address and to different addresses. It also holds a write in the holding register through a long run of reads, to check that the bypass and the array path both return the right data in that situation.

// File: rtl/latewr_pkg.sv
package latewr_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_kind_t;
endpackage

// File: rtl/latewr_stage.sv
module latewr_stage
  import latewr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_kind_t     cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wa_vld,
  output logic          hold_vld,
  output logic [AW-1:0] hold_addr,
  output logic [DW-1:0] hold_data,
  output logic          arr_we
);
  logic [AW-1:0] wa_addr;

  // Commit the held entry on any edge without a read, or when new data
  // is about to replace it.
  always_comb arr_we = hold_vld && ((cmd_kind != CMD_READ) || wa_vld);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wa_vld    <= 1'b0;
      wa_addr   <= '0;
      hold_vld  <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      wa_vld <= (cmd_kind == CMD_WRITE);
      if (cmd_kind == CMD_WRITE) wa_addr <= cmd_addr;
      if (wa_vld) begin
        hold_vld  <= 1'b1;
        hold_addr <= wa_addr;
        hold_data <= wr_data;
      end else if (arr_we) begin
        hold_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/latewr_array.sv
module latewr_array #(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb rdata = mem[raddr];
endmodule

// File: rtl/latewr_rdpath.sv
module latewr_rdpath
  import latewr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_kind_t     cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic          hold_vld,
  input  logic [AW-1:0] hold_addr,
  input  logic [DW-1:0] hold_data,
  input  logic [DW-1:0] arr_rdata,
  output logic [AW-1:0] rd_addr_q,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic          rd_pend;
  logic          hit;
  logic [DW-1:0] sel_data;

  // The held entry is always newer than the array copy.
  always_comb begin
    hit      = hold_vld && (hold_addr == rd_addr_q);
    sel_data = hit ? hold_data : arr_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      rd_addr_q <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_pend <= (cmd_kind == CMD_READ);
      if (cmd_kind == CMD_READ) rd_addr_q <= cmd_addr;
      rd_valid <= rd_pend;
      if (rd_pend) rd_data <= sel_data;
    end
  end
endmodule

// File: rtl/latewr_sram.sv
module latewr_sram
  import latewr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] wr_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  cmd_kind_t     cmd_kind;
  logic          wa_vld;
  logic          hold_vld;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;
  logic          arr_we;
  logic [AW-1:0] rd_addr_q;
  logic [DW-1:0] arr_rdata;

  always_comb begin
    if (!cmd_valid)    cmd_kind = CMD_IDLE;
    else if (cmd_write) cmd_kind = CMD_WRITE;
    else               cmd_kind = CMD_READ;
  end

  latewr_stage #(.AW(AW), .DW(DW)) i_stage (
    .clk(clk), .rst_n(rst_n), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .wr_data(wr_data), .wa_vld(wa_vld), .hold_vld(hold_vld),
    .hold_addr(hold_addr), .hold_data(hold_data), .arr_we(arr_we)
  );

  latewr_array #(.AW(AW), .DW(DW)) i_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(hold_addr),
    .wdata(hold_data), .raddr(rd_addr_q), .rdata(arr_rdata)
  );

  latewr_rdpath #(.AW(AW), .DW(DW)) i_rdpath (
    .clk(clk), .rst_n(rst_n), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .hold_vld(hold_vld), .hold_addr(hold_addr), .hold_data(hold_data),
    .arr_rdata(arr_rdata), .rd_addr_q(rd_addr_q), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/latewr_sram_chk.sv
module latewr_sram_chk #(
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_write,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          wa_vld,
  input logic          hold_vld,
  input logic          arr_we
);
  // R2: every read returns two edges later
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write) |-> ##2 rd_valid);

  // R2: no return without a read two edges earlier
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid && !cmd_write, 2));

  // R7: output holds between reads
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

  // R3: sampled write data lands in the holding register
  a_r3_land: assert property (@(posedge clk) disable iff (!rst_n)
    wa_vld |=> hold_vld);

  // R8: a held entry drains on an edge with no read and no new data
  a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && !(cmd_valid && !cmd_write) && !wa_vld) |=> !hold_vld);

  // R8: the array is written only from an occupied holding register
  a_r8_we_src: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> hold_vld);
endmodule

bind latewr_sram latewr_sram_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .rd_valid(rd_valid), .rd_data(rd_data), .wa_vld(wa_vld),
  .hold_vld(hold_vld), .arr_we(arr_we)
);

// File: tb/test_latewr_sram.sv
module test_latewr_sram;
  localparam int AW    = 4;
  localparam int DW    = 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] model [DEPTH];
  logic          owe = 1'b0;
  logic [DW-1:0] owe_d = '0;
  logic          s1v = 1'b0, s2v = 1'b0;
  logic [DW-1:0] s1d = '0, s2d = '0;
  string         s1tag = "", s2tag = "";
  logic [DW-1:0] last_rd = '0;

  always #2.5 clk = ~clk;

  latewr_sram #(.AW(AW), .DW(DW)) i_latewr_sram (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: check the output due now, then drive the next command.
  task automatic issue(input logic v, input logic w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    if (s2v) begin
      chk(rd_valid === 1'b1 && rd_data === s2d, s2tag,
          {rd_valid, rd_data}, {1'b1, s2d});
      last_rd = s2d;
    end else begin
      chk(rd_valid === 1'b0 && rd_data === last_rd, "R7",
          {rd_valid, rd_data}, {1'b0, last_rd});
    end
    cmd_valid = v;
    cmd_write = w;
    cmd_addr  = a;
    wr_data   = owe ? owe_d : DW'($urandom());
    owe   = v && w;
    owe_d = d;
    if (v && w) model[a] = d;
    s2v = s1v; s2d = s1d; s2tag = s1tag;
    s1v = v && !w; s1d = model[a]; s1tag = tag;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    issue(1'b1, 1'b1, a, d, "");
  endtask
  task automatic rd(input logic [AW-1:0] a, input string tag);
    issue(1'b1, 1'b0, a, '0, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(1'b0, 1'b0, AW'($urandom()), '0, "");
  endtask

  task automatic t_reset;
    chk(rd_valid === 1'b0 && rd_data === '0, "R1", {rd_valid, rd_data}, '0);
    for (int i = 0; i < DEPTH; i++) rd(AW'(i), "R1");
    idle(2);
  endtask

  task automatic t_latency;
    wr(4'd3, 9'h0A5);
    idle(2);
    rd(4'd3, "R2");
    idle(3);
  endtask

  task automatic t_bypass;
    wr(4'd5, 9'h1C3);
    rd(4'd5, "R4");
    idle(2);
    wr(4'd6, 9'h044);
    rd(4'd6, "R4");
    rd(4'd6, "R4");
    idle(2);
  endtask

  task automatic t_alternate;
    for (int i = 0; i < 8; i++) begin
      wr(AW'(i + 8), DW'(9'h100 + i * 7));
      rd(AW'(i + 8), "R5");
    end
    for (int i = 0; i < 8; i++) begin
      wr(AW'(15 - i), DW'(9'h0F0 ^ i));
      rd(AW'(i + 8), "R5");
    end
    idle(2);
  endtask

  task automatic t_same_addr;
    wr(4'd2, 9'h011);
    wr(4'd2, 9'h122);
    rd(4'd2, "R6");
    rd(4'd2, "R6");
    idle(3);
    rd(4'd2, "R6");
    wr(4'd7, 9'h0AA);
    wr(4'd1, 9'h155);
    rd(4'd7, "R6");
    rd(4'd1, "R6");
    idle(2);
  endtask

  task automatic t_ignore;
    wr(4'd9, 9'h07E);
    idle(4);
    rd(4'd9, "R3");
    rd(4'd9, "R3");
    idle(2);
  endtask

  task automatic t_idle;
    rd(4'd5, "R7");
    idle(6);
    rd(4'd9, "R7");
    idle(5);
  endtask

  task automatic t_long_reads;
    wr(4'd12, 9'h1E1);
    wr(4'd13, 9'h0D2);
    for (int i = 0; i < 12; i++) rd((i % 2 == 0) ? 4'd13 : AW'(i), "R8");
    idle(1);
    rd(4'd13, "R8");
    rd(4'd12, "R8");
    idle(2);
  endtask

  task automatic t_array;
    for (int i = 0; i < DEPTH; i++) rd(AW'(i), "R9");
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_bypass();
    t_alternate();
    t_same_addr();
    t_ignore();
    t_idle();
    t_long_reads();
    t_array();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule